// File: doc/BRIEF.md
# Annunciator Backplane Waveform Generator

This block drives the static segments of a small liquid crystal display: a handful of stand-alone annunciator symbols sharing one backplane electrode. It divides the display oscillator tick stream down to a square wave of 50% duty on the backplane. Each annunciator output is a square wave at the same rate. An enabled symbol is driven in antiphase with the backplane, so the segment sees an AC voltage and turns dark. A disabled symbol is driven in phase, so it sees no voltage. When no symbol is enabled, every annunciator output rests at 0.

The host sets the symbol states one at a time. It pulses a command strobe and supplies a symbol select code and an on/off bit. An oscillator enable input starts and stops the divider. While the oscillator is stopped, the backplane is held low and the divider count is held at zero, so the first backplane edge after a restart comes after a fixed number of ticks. The block has no connection to the graphic display on/off state. The analog drive levels and the pads are outside this block.

Top module: `ann_backplane_gen`

## Requirements
- R1: While `osc_en` is high, `bp` changes value only at a clock edge where `osc_tick` is high, and it toggles once for every HALF_TICKS ticks (640 by default, which divides the oscillator rate by 1280), giving 50% duty.
- R2: While `osc_en` is low, `bp` is 0 from the next clock edge and the divider count is held at zero. After `osc_en` rises, the first rising edge of `bp` comes at the HALF_TICKS-th tick.
- R3: While the oscillator runs and at least one symbol is enabled, the output of an enabled symbol is the inverse of `bp`.
- R4: While the oscillator runs and at least one symbol is enabled, the output of a disabled symbol equals `bp`.
- R5: When no symbol is enabled, all `ann` bits are 0.
- R6: A clock edge with `cmd_strobe` high and `cmd_sel` equal to 0, 1 or 2 sets the state of `ann[0]`, `ann[1]` or `ann[2]` to `cmd_on` (1 means on). The new state shows on the outputs from that edge on.
- R7: A strobe with `cmd_sel` equal to 3 changes no symbol state.
- R8: After reset, all symbols are off and `bp` and `ann` are 0.
- R9: While the oscillator is stopped, all `ann` bits are 0, so no segment is left with a DC voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator running; low stops and clears the divider |
| osc_tick | input | 1 | One-cycle pulse per display oscillator period |
| cmd_strobe | input | 1 | Symbol state command valid |
| cmd_sel | input | 2 | Symbol select code (0..2 valid, 3 ignored) |
| cmd_on | input | 1 | New state for the selected symbol, 1 = on |
| bp | output | 1 | Backplane square wave |
| ann | output | 3 | Symbol frontplane square waves |

## Verification
The assertions assume that `osc_tick` is a clean one-cycle pulse sampled with `osc_en`, and that a command is a single-cycle strobe whose select and on bits are valid in the strobe cycle. Ticks that arrive while `osc_en` is low must have no effect. The bench drives every input at the falling clock edge and holds it for a whole cycle. It uses tick patterns with gaps, a full cycle through all eight combinations of symbol states, and the reserved select code. It also stops and restarts the oscillator in the middle of a half period. This keeps the stimulus within those assumptions while it reaches every state of the divider.

// File: rtl/ann_bp_pkg.sv
package ann_bp_pkg;

  // Frontplane level for one symbol: antiphase when on, in phase when off,
  // parked at zero when the oscillator is stopped or every symbol is off.
  function automatic logic seg_level(input logic phase, input logic on,
                                     input logic any_on, input logic running);
    if (!running || !any_on) return 1'b0;
    return phase ^ on;
  endfunction

  // True on the tick that closes a half period.
  function automatic logic half_wrap(input int unsigned count,
                                     input int unsigned half_ticks);
    return count == half_ticks - 1;
  endfunction

endpackage

// File: rtl/ann_bp_divider.sv
module ann_bp_divider #(
  parameter int unsigned HALF_TICKS = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic osc_tick,
  output logic phase,
  output logic running,
  output logic half_done
);
  import ann_bp_pkg::*;

  localparam int unsigned CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign half_done = osc_en && osc_tick && half_wrap(int'(cnt_q), HALF_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase   <= 1'b0;
      running <= 1'b0;
    end else begin
      running <= osc_en;
      if (!osc_en) begin
        cnt_q <= '0;
        phase <= 1'b0;
      end else if (osc_tick) begin
        if (half_done) begin
          cnt_q <= '0;
          phase <= ~phase;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ann_enable_regs.sv
module ann_enable_regs #(
  parameter int unsigned NUM_ANN = 3,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_strobe,
  input  logic [SEL_W-1:0]   cmd_sel,
  input  logic               cmd_on,
  output logic [NUM_ANN-1:0] on_q
);

  for (genvar i = 0; i < NUM_ANN; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_q[i] <= 1'b0;
      end else if (cmd_strobe && cmd_sel == SEL_W'(i)) begin
        on_q[i] <= cmd_on;
      end
    end
  end

endmodule

// File: rtl/ann_backplane_gen.sv
module ann_backplane_gen #(
  parameter int unsigned HALF_TICKS = 640,
  parameter int unsigned NUM_ANN    = 3,
  localparam int unsigned SEL_W     = $clog2(NUM_ANN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_en,
  input  logic               osc_tick,
  input  logic               cmd_strobe,
  input  logic [SEL_W-1:0]   cmd_sel,
  input  logic               cmd_on,
  output logic               bp,
  output logic [NUM_ANN-1:0] ann
);
  import ann_bp_pkg::*;

  logic               phase;
  logic               run_q;
  logic               half_done;
  logic [NUM_ANN-1:0] ann_on;
  logic               any_on;

  ann_bp_divider #(.HALF_TICKS(HALF_TICKS)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .osc_tick (osc_tick),
    .phase    (phase),
    .running  (run_q),
    .half_done(half_done)
  );

  ann_enable_regs #(.NUM_ANN(NUM_ANN), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_strobe(cmd_strobe),
    .cmd_sel   (cmd_sel),
    .cmd_on    (cmd_on),
    .on_q      (ann_on)
  );

  assign any_on = |ann_on;
  assign bp     = phase;

  for (genvar i = 0; i < NUM_ANN; i++) begin : g_seg
    assign ann[i] = seg_level(phase, ann_on[i], any_on, run_q);
  end

endmodule

// File: rtl/ann_backplane_gen_chk.sv
module ann_backplane_gen_chk #(
  parameter int unsigned NUM_ANN = 3,
  parameter int unsigned SEL_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               osc_en,
  input logic               osc_tick,
  input logic               cmd_strobe,
  input logic [SEL_W-1:0]   cmd_sel,
  input logic               cmd_on,
  input logic               bp,
  input logic [NUM_ANN-1:0] ann,
  input logic [NUM_ANN-1:0] ann_on,
  input logic               run_q,
  input logic               half_done
);

  assert_no_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !osc_tick) |=> $stable(bp));

  assert_half_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |=> (bp != $past(bp)));

  assert_bp_low_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !bp);

  assert_polarity_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (ann_on != '0)) |-> ((ann ^ {NUM_ANN{bp}}) == ann_on));

  assert_all_off_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ann_on == '0) |-> (ann == '0));

  assert_reserved_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && cmd_sel >= SEL_W'(NUM_ANN)) |=> $stable(ann_on));

  assert_stopped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (ann == '0));

  for (genvar i = 0; i < NUM_ANN; i++) begin : g_cmd
    assert_cmd_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_strobe && cmd_sel == SEL_W'(i)) |=> (ann_on[i] == $past(cmd_on)));
  end

endmodule

bind ann_backplane_gen ann_backplane_gen_chk #(.NUM_ANN(NUM_ANN), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_en    (osc_en),
  .osc_tick  (osc_tick),
  .cmd_strobe(cmd_strobe),
  .cmd_sel   (cmd_sel),
  .cmd_on    (cmd_on),
  .bp        (bp),
  .ann       (ann),
  .ann_on    (ann_on),
  .run_q     (run_q),
  .half_done (half_done)
);

// File: tb/ann_backplane_gen_bench.sv
module ann_backplane_gen_bench;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       osc_tick = 1'b0;
  logic       cmd_strobe = 1'b0;
  logic [1:0] cmd_sel = 2'd0;
  logic       cmd_on = 1'b0;
  logic       bp;
  logic [2:0] ann;

  int checks = 0;
  int fails  = 0;
  int nticks = 0;
  logic       m_run = 1'b0;
  logic [2:0] m_on  = 3'b000;

  ann_backplane_gen #(.HALF_TICKS(HALF), .NUM_ANN(3)) u_ann_backplane_gen (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_tick(osc_tick),
    .cmd_strobe(cmd_strobe), .cmd_sel(cmd_sel), .cmd_on(cmd_on),
    .bp(bp), .ann(ann)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare the outputs with the model after an edge.
  task automatic compare();
    logic eb;
    logic [2:0] ea;
    eb = m_run ? logic'((nticks / HALF) % 2) : 1'b0;
    if (m_run) chk("R1", {3'b0, bp}, {3'b0, eb});
    else       chk("R2", {3'b0, bp}, 4'h0);
    if (!m_run) begin
      chk("R9", {1'b0, ann}, 4'h0);
    end else if (m_on == 3'b000) begin
      chk("R5", {1'b0, ann}, 4'h0);
    end else begin
      for (int i = 0; i < 3; i++) begin
        ea[i] = eb ^ m_on[i];
        if (m_on[i]) chk("R3", {3'b0, ann[i]}, {3'b0, ea[i]});
        else         chk("R4", {3'b0, ann[i]}, {3'b0, ea[i]});
      end
    end
  endtask

  // One clock: drive at falling edge, update model at rising edge, check after.
  task automatic step(input logic en, input logic tick, input logic stb,
                      input logic [1:0] sel, input logic on);
    @(negedge clk);
    osc_en = en; osc_tick = tick; cmd_strobe = stb; cmd_sel = sel; cmd_on = on;
    @(posedge clk);
    if (!en) nticks = 0;
    else if (tick) nticks++;
    m_run = en;
    if (stb && sel != 2'd3) m_on[sel] = on;
    #1;
    compare();
  endtask

  task automatic run(input int n, input int gap);
    for (int c = 0; c < n; c++) step(1'b1, (gap == 0) || (c % gap != 0), 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R8", {3'b0, bp}, 4'h0);
        chk("R8", {1'b0, ann}, 4'h0);
        // Stopped with ticks arriving: nothing moves.
        for (int c = 0; c < 6; c++) step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        // All off, running.
        run(4 * HALF, 0);
        // Restart: first rise after exactly HALF ticks.
        step(1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        for (int c = 0; c < HALF - 1; c++) step(1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
        chk("R2", {3'b0, bp}, 4'h0);
        step(1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
        chk("R2", {3'b0, bp}, 4'h1);
        // Sweep all symbol combinations with several tick patterns.
        for (int m = 0; m < 8; m++) begin
          for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 2'(i), m[i]);
          run(4 * HALF + 3, 3);
          run(2 * HALF + 1, 0);
        end
        // Reserved select code leaves the state alone.
        step(1'b1, 1'b0, 1'b1, 2'd0, 1'b1);
        step(1'b1, 1'b0, 1'b1, 2'd1, 1'b0);
        step(1'b1, 1'b0, 1'b1, 2'd2, 1'b0);
        step(1'b1, 1'b1, 1'b1, 2'd3, 1'b1);
        chk("R7", {1'b0, ann[2:1]}, {1'b0, {2{bp}}});
        chk("R7", {3'b0, ann[0]}, {3'b0, ~bp});
        step(1'b1, 1'b1, 1'b1, 2'd3, 1'b0);
        chk("R7", {3'b0, ann[0]}, {3'b0, ~bp});
        // Command write visible at the next edge.
        step(1'b1, 1'b0, 1'b1, 2'd2, 1'b1);
        chk("R6", {3'b0, ann[2]}, {3'b0, ~bp});
        run(3 * HALF, 2);
        // Stop mid half period with symbols on.
        step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        chk("R9", {1'b0, ann}, 4'h0);
        run(3 * HALF, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule